// File: doc/BRIEF.md
# Windowed Address Translation Unit

This block holds two banks of address translation windows, one for traffic leaving the host side (outbound) and one for traffic arriving from the link (inbound). Each bank has a parameterised number of windows, sixteen by default. Software never addresses a window directly. It first writes a viewport select register to choose a direction and a window index. It then reads and writes that window's base, limit, target and two control words through one shared group of register offsets.

Programming is staged. Writes to base, limit, target and the first control word change only a pending copy of the window. The window's live settings, which lookups use, are loaded from that pending copy at the moment software writes the second control word. Bit 31 of that write becomes the window's enable. A window whose type is non-zero works as a configuration window: a hit reports the bus and device/function numbers held in its target instead of a translated memory address.

Lookups use a valid/ready stream. A request carries a 64-bit address and a direction bit. One cycle later the result presents a hit flag, the output address, a configuration flag, and the bus and device/function numbers. The request side is ready whenever the result register is empty or is being drained in the same cycle. While the result is valid and not accepted, it holds steady and no new request is taken. Register accesses use plain pins. A write takes effect at the clock edge, and read data is a combinational function of the register address.

Top module: `atu_window_bank`

## Requirements
- R1: Writing the viewport select register (byte offset 0x900) keeps only bit 31 (1 = inbound, 0 = outbound) and the low log2(NWIN) bits (window index). Every other bit reads back as zero.
- R2: Base low/high (0x90C/0x910), limit (0x914), target low/high (0x918/0x91C) and control words 1/2 (0x904/0x908) read back the selected window's pending values. A write to one 32-bit half leaves the other half unchanged.
- R3: Writes to base, limit, target and control word 1 do not change lookup results until control word 2 is written for that window.
- R4: An enabled memory window (control word 1 equal to 0) hits when base <= A <= limit, with the 32-bit limit zero-extended. It returns target + (A - base) with the configuration flag clear and bus and devfn zero.
- R5: A lookup that hits no enabled window of its direction returns hit 0, configuration flag 0, bus and devfn 0, and the address unchanged.
- R6: An enabled window whose control word 1 is non-zero hits over the same range. It returns the configuration flag set, bus = target[31:24], devfn = target[23:16], and address A - base.
- R7: When several enabled windows of one direction hit, the lowest index decides the result.
- R8: A lookup uses only the windows of its own direction (lk_inbound = 1 selects the inbound bank).
- R9: After reset every window has pending and live base 0, target 0, limit 0xFFFFFFFF, type memory and is disabled. The exception is inbound window 0, which is enabled and reads 0x80000000 from control word 2. The viewport register reads 0.
- R10: lk_ready is high exactly when the result register is empty or res_ready is high. A result is presented the cycle after acceptance and is held stable while res_valid is high and res_ready is low.
- R11: Writing control word 2 with bit 31 clear removes the window from lookups.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| lk_valid | input | 1 | Lookup request valid |
| lk_ready | output | 1 | Lookup request accepted when high with lk_valid |
| lk_inbound | input | 1 | Lookup direction, 1 = inbound |
| lk_addr | input | 64 | Address to translate |
| res_valid | output | 1 | Result valid |
| res_ready | input | 1 | Result consumer ready |
| res_hit | output | 1 | A window matched |
| res_cfg | output | 1 | Matching window is a configuration window |
| res_bus | output | 8 | Bus number for configuration hits |
| res_devfn | output | 8 | Device/function number for configuration hits |
| res_addr | output | 64 | Translated or passed-through address |

## Verification
The checker watches the stream handshake on every cycle. It confirms that an accepted request yields a result on the next cycle and that a stalled result does not change. It also confirms that a miss returns exactly the address that was accepted, that non-configuration results carry zero bus and devfn, and that the viewport readback never shows discarded bits. The translation arithmetic, lowest-index priority, direction separation and the staged effect of control word 2 depend on the programming history. Only the bench's scenarios can show them, by comparing each result with a model that follows the same writes.

// File: rtl/atu_pkg.sv
package atu_pkg;
  localparam int REG_AW = 12;

  localparam logic [REG_AW-1:0] OFS_VIEW   = 12'h900;
  localparam logic [REG_AW-1:0] OFS_CW1    = 12'h904;
  localparam logic [REG_AW-1:0] OFS_CW2    = 12'h908;
  localparam logic [REG_AW-1:0] OFS_BASE_L = 12'h90C;
  localparam logic [REG_AW-1:0] OFS_BASE_H = 12'h910;
  localparam logic [REG_AW-1:0] OFS_LIMIT  = 12'h914;
  localparam logic [REG_AW-1:0] OFS_TGT_L  = 12'h918;
  localparam logic [REG_AW-1:0] OFS_TGT_H  = 12'h91C;

  typedef struct packed {
    logic [63:0] base;
    logic [31:0] limit;
    logic [63:0] target;
    logic        is_mem;
    logic        en;
  } win_t;

  typedef struct packed {
    logic        hit;
    logic        cfg;
    logic [7:0]  bus;
    logic [7:0]  devfn;
    logic [63:0] addr;
  } lk_res_t;
endpackage

// File: rtl/atu_regs.sv
module atu_regs
  import atu_pkg::*;
#(
  parameter int NWIN = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output win_t              act_o [2*NWIN]
);
  localparam int IDXW = $clog2(NWIN);
  localparam int TOT  = 2 * NWIN;
  localparam int SELW = IDXW + 1;

  logic            vp_dir;
  logic [IDXW-1:0] vp_idx;
  logic [SELW-1:0] sel;

  logic [63:0] p_base [TOT];
  logic [31:0] p_lim  [TOT];
  logic [63:0] p_tgt  [TOT];
  logic [31:0] p_cw1  [TOT];
  logic [31:0] p_cw2  [TOT];
  win_t        act    [TOT];

  assign sel = {vp_dir, vp_idx};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vp_dir <= 1'b0;
      vp_idx <= '0;
      for (int k = 0; k < TOT; k++) begin
        p_base[k] <= '0;
        p_lim[k]  <= '1;
        p_tgt[k]  <= '0;
        p_cw1[k]  <= '0;
        p_cw2[k]  <= (k == NWIN) ? 32'h8000_0000 : 32'h0;
        act[k].base   <= '0;
        act[k].limit  <= '1;
        act[k].target <= '0;
        act[k].is_mem <= 1'b1;
        act[k].en     <= (k == NWIN);
      end
    end else if (reg_we) begin
      case (reg_addr)
        OFS_VIEW: begin
          vp_dir <= reg_wdata[31];
          vp_idx <= reg_wdata[IDXW-1:0];
        end
        OFS_CW1:    p_cw1[sel] <= reg_wdata;
        OFS_CW2: begin
          p_cw2[sel]      <= reg_wdata;
          act[sel].base   <= p_base[sel];
          act[sel].limit  <= p_lim[sel];
          act[sel].target <= p_tgt[sel];
          act[sel].is_mem <= (p_cw1[sel] == 32'h0);
          act[sel].en     <= reg_wdata[31];
        end
        OFS_BASE_L: p_base[sel][31:0]  <= reg_wdata;
        OFS_BASE_H: p_base[sel][63:32] <= reg_wdata;
        OFS_LIMIT:  p_lim[sel]         <= reg_wdata;
        OFS_TGT_L:  p_tgt[sel][31:0]   <= reg_wdata;
        OFS_TGT_H:  p_tgt[sel][63:32]  <= reg_wdata;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (reg_addr)
      OFS_VIEW:   reg_rdata = {vp_dir, {(31-IDXW){1'b0}}, vp_idx};
      OFS_CW1:    reg_rdata = p_cw1[sel];
      OFS_CW2:    reg_rdata = p_cw2[sel];
      OFS_BASE_L: reg_rdata = p_base[sel][31:0];
      OFS_BASE_H: reg_rdata = p_base[sel][63:32];
      OFS_LIMIT:  reg_rdata = p_lim[sel];
      OFS_TGT_L:  reg_rdata = p_tgt[sel][31:0];
      OFS_TGT_H:  reg_rdata = p_tgt[sel][63:32];
      default:    reg_rdata = 32'h0;
    endcase
  end

  for (genvar k = 0; k < TOT; k++) begin : g_out
    assign act_o[k] = act[k];
  end
endmodule

// File: rtl/atu_match.sv
module atu_match
  import atu_pkg::*;
#(
  parameter int NWIN = 16
) (
  input  win_t        wins [NWIN],
  input  logic [63:0] addr,
  output lk_res_t     res
);
  logic [NWIN-1:0] hv;
  logic            found;
  logic [63:0]     pk_base;
  logic [63:0]     pk_tgt;
  logic            pk_mem;
  logic [63:0]     offs;

  for (genvar i = 0; i < NWIN; i++) begin : g_cmp
    assign hv[i] = wins[i].en && (addr >= wins[i].base) &&
                   (addr <= {32'h0, wins[i].limit});
  end

  // Scan from the top so the lowest matching index is written last
  always_comb begin
    found   = 1'b0;
    pk_base = '0;
    pk_tgt  = '0;
    pk_mem  = 1'b1;
    for (int i = NWIN - 1; i >= 0; i--) begin
      if (hv[i]) begin
        found   = 1'b1;
        pk_base = wins[i].base;
        pk_tgt  = wins[i].target;
        pk_mem  = wins[i].is_mem;
      end
    end
  end

  assign offs = addr - pk_base;

  always_comb begin
    res = '0;
    if (!found) begin
      res.addr = addr;
    end else if (pk_mem) begin
      res.hit  = 1'b1;
      res.addr = pk_tgt + offs;
    end else begin
      res.hit   = 1'b1;
      res.cfg   = 1'b1;
      res.bus   = pk_tgt[31:24];
      res.devfn = pk_tgt[23:16];
      res.addr  = offs;
    end
  end
endmodule

// File: rtl/atu_resp_stage.sv
module atu_resp_stage
  import atu_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    in_valid,
  output logic    in_ready,
  input  lk_res_t in_res,
  output logic    out_valid,
  input  logic    out_ready,
  output lk_res_t out_res
);
  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_res   <= '0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) out_res <= in_res;
    end
  end
endmodule

// File: rtl/atu_window_bank.sv
module atu_window_bank
  import atu_pkg::*;
#(
  parameter int NWIN = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_we,
  input  logic [11:0] reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  input  logic        lk_valid,
  output logic        lk_ready,
  input  logic        lk_inbound,
  input  logic [63:0] lk_addr,
  output logic        res_valid,
  input  logic        res_ready,
  output logic        res_hit,
  output logic        res_cfg,
  output logic [7:0]  res_bus,
  output logic [7:0]  res_devfn,
  output logic [63:0] res_addr
);
  win_t    act      [2*NWIN];
  win_t    dir_wins [NWIN];
  lk_res_t mres;
  lk_res_t ores;

  atu_regs #(.NWIN(NWIN)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .act_o     (act)
  );

  for (genvar i = 0; i < NWIN; i++) begin : g_dir
    assign dir_wins[i] = lk_inbound ? act[NWIN+i] : act[i];
  end

  atu_match #(.NWIN(NWIN)) u_match (
    .wins (dir_wins),
    .addr (lk_addr),
    .res  (mres)
  );

  atu_resp_stage u_stage (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (lk_valid),
    .in_ready  (lk_ready),
    .in_res    (mres),
    .out_valid (res_valid),
    .out_ready (res_ready),
    .out_res   (ores)
  );

  assign res_hit   = ores.hit;
  assign res_cfg   = ores.cfg;
  assign res_bus   = ores.bus;
  assign res_devfn = ores.devfn;
  assign res_addr  = ores.addr;
endmodule

// File: rtl/atu_window_bank_chk.sv
module atu_window_bank_chk #(
  parameter int NWIN = 16
) (
  input logic        clk,
  input logic        rst_n,
  input logic [11:0] reg_addr,
  input logic [31:0] reg_rdata,
  input logic        lk_valid,
  input logic        lk_ready,
  input logic [63:0] lk_addr,
  input logic        res_valid,
  input logic        res_ready,
  input logic        res_hit,
  input logic        res_cfg,
  input logic [7:0]  res_bus,
  input logic [7:0]  res_devfn,
  input logic [63:0] res_addr
);
  localparam int IDXW = $clog2(NWIN);
  localparam logic [31:0] VP_KEEP = 32'h8000_0000 | ((32'h1 << IDXW) - 32'h1);

  logic [63:0] cap_addr;
  always_ff @(posedge clk) begin
    if (!rst_n) cap_addr <= '0;
    else if (lk_valid && lk_ready) cap_addr <= lk_addr;
  end

  AST_RESULT_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid && lk_ready |=> res_valid);  // R10
  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_ready |=> res_valid && $stable(res_addr) && $stable(res_hit) && $stable(res_cfg));  // R10
  AST_MISS_PASSTHRU: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_hit |-> res_addr == cap_addr && !res_cfg);  // R5
  AST_NONCFG_ZERO_IDS: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_cfg |-> res_bus == 8'h0 && res_devfn == 8'h0);  // R6
  AST_VIEW_DISCARD: assert property (@(posedge clk) disable iff (!rst_n)
    reg_addr == 12'h900 |-> (reg_rdata & ~VP_KEEP) == 32'h0);  // R1
endmodule

bind atu_window_bank atu_window_bank_chk #(.NWIN(NWIN)) u_chk (.*);

// File: tb/atu_window_bank_tb.sv
module atu_window_bank_tb;
  localparam int NW = 16;
  logic clk = 0, rst_n = 0;
  logic reg_we = 0; logic [11:0] reg_addr = 0; logic [31:0] reg_wdata = 0;
  logic [31:0] reg_rdata;
  logic lk_valid = 0, lk_ready, lk_inbound = 0; logic [63:0] lk_addr = 0;
  logic res_valid, res_ready = 1, res_hit, res_cfg;
  logic [7:0] res_bus, res_devfn; logic [63:0] res_addr;
  int n_chk = 0, n_bad = 0;

  always #5 clk = ~clk;

  atu_window_bank #(.NWIN(NW)) u_dut (.*);

  // reference model, index = dir*NW + window
  logic [63:0] p_base[2*NW], p_tgt[2*NW], m_base[2*NW], m_tgt[2*NW];
  logic [31:0] p_lim[2*NW], p_cw1[2*NW], p_cw2[2*NW], m_lim[2*NW];
  logic m_mem[2*NW], m_en[2*NW];
  logic v_dir; logic [3:0] v_idx;

  function automatic int cur(); return (v_dir ? NW : 0) + int'(v_idx); endfunction

  function automatic logic [81:0] exp_lk(input logic dir, input logic [63:0] a);
    for (int i = 0; i < NW; i++) begin
      int k = (dir ? NW : 0) + i;
      if (m_en[k] && a >= m_base[k] && a <= {32'h0, m_lim[k]}) begin
        if (m_mem[k]) return {2'b10, 16'h0, m_tgt[k] + (a - m_base[k])};
        return {2'b11, m_tgt[k][31:24], m_tgt[k][23:16], a - m_base[k]};
      end
    end
    return {2'b00, 16'h0, a};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [81:0] act, input logic [81:0] exp);
    n_chk++;
    if (!ok) begin n_bad++; $display("FAIL %s actual=%h expected=%h", tag, act, exp); end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    int k;
    @(negedge clk); reg_we = 1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1;
    reg_we = 0;
    k = cur();
    case (a)
      12'h900: begin v_dir = d[31]; v_idx = d[3:0]; end
      12'h904: p_cw1[k] = d;
      12'h908: begin p_cw2[k] = d; m_base[k] = p_base[k]; m_lim[k] = p_lim[k];
        m_tgt[k] = p_tgt[k]; m_mem[k] = (p_cw1[k] == 0); m_en[k] = d[31]; end
      12'h90C: p_base[k][31:0] = d;
      12'h910: p_base[k][63:32] = d;
      12'h914: p_lim[k] = d;
      12'h918: p_tgt[k][31:0] = d;
      12'h91C: p_tgt[k][63:32] = d;
      default: ;
    endcase
  endtask

  task automatic rdchk(input logic [11:0] a, input logic [31:0] e, input string tag);
    @(negedge clk); reg_addr = a; #1;
    chk(reg_rdata === e, tag, {50'h0, reg_rdata}, {50'h0, e});
  endtask

  task automatic look(input logic dir, input logic [63:0] a, input string tag);
    logic [81:0] e, g;
    e = exp_lk(dir, a);
    @(negedge clk); lk_valid = 1; lk_inbound = dir; lk_addr = a; res_ready = 1;
    @(posedge clk);
    @(negedge clk); lk_valid = 0;
    g = {res_hit, res_cfg, res_bus, res_devfn, res_addr};
    chk(res_valid === 1'b1 && g === e, tag, g, e);
  endtask

  task automatic prog(input logic dir, input int idx, input logic [63:0] b, input logic [31:0] l,
                      input logic [63:0] t, input logic [31:0] c1, input logic [31:0] c2);
    wr(12'h900, {dir, 27'h0, idx[3:0]});
    wr(12'h90C, b[31:0]); wr(12'h910, b[63:32]); wr(12'h914, l);
    wr(12'h918, t[31:0]); wr(12'h91C, t[63:32]); wr(12'h904, c1); wr(12'h908, c2);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [81:0] ea, eb, g;
    void'($urandom(32'd20240611));
    for (int k = 0; k < 2*NW; k++) begin
      p_base[k] = 0; p_tgt[k] = 0; p_lim[k] = '1; p_cw1[k] = 0; p_cw2[k] = (k == NW) ? 32'h8000_0000 : 0;
      m_base[k] = 0; m_tgt[k] = 0; m_lim[k] = '1; m_mem[k] = 1; m_en[k] = (k == NW);
    end
    v_dir = 0; v_idx = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;

    // R9 reset state
    rdchk(12'h900, 32'h0, "R9 viewport reset");
    wr(12'h900, 32'h8000_0000);
    rdchk(12'h908, 32'h8000_0000, "R9 inbound0 enabled");
    rdchk(12'h914, 32'hFFFF_FFFF, "R9 limit reset");
    look(1, 64'h1234, "R9 inbound default pass");
    look(0, 64'h1234, "R5 R9 outbound miss");
    // R1 viewport discard
    wr(12'h900, 32'hFFFF_FFFF);
    rdchk(12'h900, 32'h8000_000F, "R1 keep bit31 and index");
    wr(12'h900, 32'h0000_0013);
    rdchk(12'h900, 32'h0000_0003, "R1 drop upper index bits");
    // R2 half updates
    wr(12'h900, 32'h2);
    wr(12'h90C, 32'h1000); wr(12'h910, 32'h5);
    rdchk(12'h90C, 32'h1000, "R2 low half kept");
    rdchk(12'h910, 32'h5, "R2 high half");
    wr(12'h910, 32'h0);
    // R3 staged commit
    wr(12'h914, 32'h1FFF); wr(12'h918, 32'h8000_0000); wr(12'h91C, 32'h1); wr(12'h904, 0);
    look(0, 64'h1800, "R3 pending not active");
    wr(12'h908, 32'h8000_0000);
    look(0, 64'h1800, "R4 translate");
    look(0, 64'h1FFF, "R4 upper edge");
    look(0, 64'h2000, "R4 past limit");
    look(0, 64'h0FFF, "R4 below base");
    // R7 priority
    prog(0, 5, 64'h1800, 32'h2FFF, 64'h0, 0, 32'h8000_0000);
    look(0, 64'h1900, "R7 lowest index wins");
    look(0, 64'h2100, "R7 higher window alone");
    // R6 config window
    prog(0, 7, 64'h4000_0000, 32'h4000_FFFF, 64'h0312_0000, 32'h4, 32'h8000_0000);
    look(0, 64'h4000_0010, "R6 config ids");
    // R8 direction
    look(1, 64'h1900, "R8 inbound ignores outbound");
    // R11 disable
    prog(0, 2, 64'h1000, 32'h1FFF, 64'h1_8000_0000, 0, 32'h0);
    look(0, 64'h1900, "R11 disabled window skipped");
    // R10 back-pressure
    ea = exp_lk(0, 64'h2200); eb = exp_lk(0, 64'h4000_0020);
    @(negedge clk); lk_valid = 1; lk_inbound = 0; lk_addr = 64'h2200; res_ready = 0;
    @(posedge clk);
    @(negedge clk); lk_addr = 64'h4000_0020;
    for (int c = 0; c < 3; c++) begin
      g = {res_hit, res_cfg, res_bus, res_devfn, res_addr};
      chk(lk_ready === 1'b0 && res_valid === 1'b1 && g === ea, "R10 stall holds", g, ea);
      @(negedge clk);
    end
    res_ready = 1;
    @(posedge clk);
    @(negedge clk); lk_valid = 0;
    g = {res_hit, res_cfg, res_bus, res_devfn, res_addr};
    chk(res_valid === 1'b1 && g === eb, "R10 next after drain", g, eb);
    @(posedge clk); #1;
    chk(res_valid === 1'b0, "R10 drained", {81'h0, res_valid}, 82'h0);

    // random programming and lookups
    for (int it = 0; it < 250; it++) begin
      logic d; int w; logic [31:0] b, l; logic [63:0] t;
      d = $urandom % 2; w = $urandom % NW;
      b = $urandom & 32'h000F_FF00; l = b + ($urandom & 32'hFFFF);
      t = {$urandom, $urandom};
      wr(12'h900, {d, 27'h0, w[3:0]});
      wr(12'h90C, b); wr(12'h910, ($urandom % 8 == 0) ? 32'h1 : 32'h0);
      wr(12'h914, l); wr(12'h918, t[31:0]); wr(12'h91C, t[63:32]);
      wr(12'h904, ($urandom % 4 == 0) ? ($urandom | 1) : 32'h0);
      rdchk(12'h90C, b, "R2 random readback");
      if ($urandom % 5 != 0) wr(12'h908, {$urandom % 4 != 0, 31'h0});
      for (int j = 0; j < 3; j++) begin
        logic [63:0] a;
        a = {($urandom % 16 == 0) ? $urandom : 32'h0, $urandom & 32'h001F_FFFF};
        look($urandom % 2, a, "R4 R6 R7 random lookup");
      end
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule